// File: doc/BRIEF.md
# Speculative-Read Line Tracker

This block sits beside the tag array of a level-one data cache. It keeps one mark per cache line for each hardware strand. A mark records that the strand read the line while speculating, or while running a transaction. When a marked line leaves the cache, the strands that marked it are told that their speculation has failed. A line can leave either because a coherence invalidation removes it or because a victim replacement evicts it. The block therefore gives load atomicity without a load queue: a speculative read stays valid only while its line stays in the cache.

Each strand has a small controller with three states:
- IDLE: no marks are held.
- ARMED: at least one mark is held.
- FAILED: a conflict has been reported.

The transitions are:
- IDLE→ARMED on an accepted load.
- IDLE→FAILED or ARMED→FAILED on a conflict.
- Any state→IDLE on an end command.
- Every other case holds the current state.

The end command stands for a join or a fail. It clears every mark of the strand in one cycle. While a strand is FAILED, it ignores loads and reports no further conflicts until its end command.

Top module: `spec_read_tracker`

## Requirements
- R1: While reset is low, and after reset is released, every spec_fail_o bit is 0 and no strand holds a mark. An invalidate or evict of a line that was marked before reset produces no fail.
- R2: A load from strand s to line L (ld_valid_i=1, ld_line_i=L, ld_strand_i=s) marks L for s. A later invalidate of L raises spec_fail_o[s] in the cycle after the edge that samples the invalidate. The bit stays high for exactly one cycle.
- R3: An evict of a line that strand s has marked raises spec_fail_o[s] with the same timing as R2. Line indices 0 and NUM_LINES-1 behave like any other line.
- R4: A conflict fails only the strands that marked the affected line, and every such strand fails. Invalidating a line that no strand has marked produces no fail.
- R5: An end command (end_mask_i bit s = 1) clears all marks of strand s in one cycle and returns it to IDLE. The marks of the other strands are kept.
- R6: A load and an invalidate, or a load and an evict, to the same line in the same cycle count as a conflict for the loading strand.
- R7: After a fail, the strand is FAILED. Further conflicts give no pulse and its loads are ignored until its end command.
- R8: An end command for strand s takes priority over a conflict and over a load for s in the same cycle. No fail is raised and the load is dropped.
- R9: An invalidate and an evict of different lines in the same cycle are both checked. A strand hit by both receives a single one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid_i | input | 1 | Speculative load hit event |
| ld_line_i | input | LINE_W | Line index of the load |
| ld_strand_i | input | STRAND_W | Strand issuing the load |
| inv_valid_i | input | 1 | Coherence invalidation event |
| inv_line_i | input | LINE_W | Line being invalidated |
| evict_valid_i | input | 1 | Victim replacement event |
| evict_line_i | input | LINE_W | Line being evicted |
| end_mask_i | input | NUM_STRANDS | Join or fail command per strand; clears that strand's marks |
| spec_fail_o | output | NUM_STRANDS | Registered one-cycle speculation-fail pulse per strand |

## Verification
Marks and controller state change at the rising edge that samples an event. A fail pulse is visible for the whole cycle after that edge, and a mark set at one edge is seen by an event at the next edge. The bench drives each stimulus on a falling edge and waits through one rising edge. It compares spec_fail_o at the following falling edge, so every expected value belongs to the row that caused it. Rows with idle inputs after a pulse confirm that the pulse lasts exactly one cycle.

// File: rtl/spec_track_pkg.sv
package spec_track_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_FAILED = 2'd2
    } strand_state_e;

endpackage

// File: rtl/spec_mark_array.sv
module spec_mark_array #(
    parameter int NUM_LINES   = 64,
    parameter int NUM_STRANDS = 2,
    localparam int LINE_W     = $clog2(NUM_LINES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_STRANDS-1:0] set_en_i,
    input  logic [LINE_W-1:0]      set_line_i,
    input  logic [NUM_STRANDS-1:0] flush_i,
    input  logic                   inv_valid_i,
    input  logic [LINE_W-1:0]      inv_line_i,
    input  logic                   evict_valid_i,
    input  logic [LINE_W-1:0]      evict_line_i,
    output logic [NUM_STRANDS-1:0] conflict_o
);

    // Same-cycle forwarding of a load onto an invalidate/evict line
    logic inv_same;
    logic ev_same;
    assign inv_same = (set_line_i == inv_line_i);
    assign ev_same  = (set_line_i == evict_line_i);

    for (genvar s = 0; s < NUM_STRANDS; s++) begin : g_strand
        logic [NUM_LINES-1:0] marks;
        logic                 inv_hit;
        logic                 ev_hit;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                marks <= '0;
            end else if (flush_i[s]) begin
                marks <= '0;
            end else if (set_en_i[s]) begin
                marks[set_line_i] <= 1'b1;
            end
        end

        always_comb begin
            inv_hit = inv_valid_i &
                      (marks[inv_line_i] | (set_en_i[s] & inv_same));
            ev_hit  = evict_valid_i &
                      (marks[evict_line_i] | (set_en_i[s] & ev_same));
            conflict_o[s] = inv_hit | ev_hit;
        end
    end

endmodule

// File: rtl/spec_strand_fsm.sv
module spec_strand_fsm
    import spec_track_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic end_i,
    input  logic track_i,
    input  logic conflict_i,
    output logic accepting_o,
    output logic fail_o
);

    strand_state_e state_q;
    strand_state_e state_d;
    logic          report;

    always_comb begin
        state_d = state_q;
        report  = 1'b0;
        if (end_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (conflict_i) begin
                        state_d = ST_FAILED;
                        report  = 1'b1;
                    end else if (track_i) begin
                        state_d = ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (conflict_i) begin
                        state_d = ST_FAILED;
                        report  = 1'b1;
                    end
                end
                ST_FAILED: state_d = ST_FAILED;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fail_o <= 1'b0;
        else        fail_o <= report;
    end

    assign accepting_o = (state_q != ST_FAILED);

endmodule

// File: rtl/spec_read_tracker.sv
module spec_read_tracker #(
    parameter int NUM_LINES   = 64,
    parameter int NUM_STRANDS = 2,
    localparam int LINE_W     = $clog2(NUM_LINES),
    localparam int STRAND_W   = (NUM_STRANDS > 1) ? $clog2(NUM_STRANDS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ld_valid_i,
    input  logic [LINE_W-1:0]      ld_line_i,
    input  logic [STRAND_W-1:0]    ld_strand_i,
    input  logic                   inv_valid_i,
    input  logic [LINE_W-1:0]      inv_line_i,
    input  logic                   evict_valid_i,
    input  logic [LINE_W-1:0]      evict_line_i,
    input  logic [NUM_STRANDS-1:0] end_mask_i,
    output logic [NUM_STRANDS-1:0] spec_fail_o
);

    logic [NUM_STRANDS-1:0] accepting;
    logic [NUM_STRANDS-1:0] set_en;
    logic [NUM_STRANDS-1:0] conflict;

    for (genvar s = 0; s < NUM_STRANDS; s++) begin : g_ctl
        // End command wins over a load; a failed strand drops loads
        assign set_en[s] = ld_valid_i & (ld_strand_i == STRAND_W'(s)) &
                           accepting[s] & ~end_mask_i[s];

        spec_strand_fsm u_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .end_i       (end_mask_i[s]),
            .track_i     (set_en[s]),
            .conflict_i  (conflict[s]),
            .accepting_o (accepting[s]),
            .fail_o      (spec_fail_o[s])
        );
    end

    spec_mark_array #(
        .NUM_LINES   (NUM_LINES),
        .NUM_STRANDS (NUM_STRANDS)
    ) u_marks (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_en_i      (set_en),
        .set_line_i    (ld_line_i),
        .flush_i       (end_mask_i),
        .inv_valid_i   (inv_valid_i),
        .inv_line_i    (inv_line_i),
        .evict_valid_i (evict_valid_i),
        .evict_line_i  (evict_line_i),
        .conflict_o    (conflict)
    );

endmodule

// File: rtl/spec_read_tracker_chk.sv
module spec_read_tracker_chk #(
    parameter int NUM_STRANDS = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   inv_valid_i,
    input logic                   evict_valid_i,
    input logic [NUM_STRANDS-1:0] end_mask_i,
    input logic [NUM_STRANDS-1:0] spec_fail_o
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (spec_fail_o == '0))
        else $error("R1: fail output active after reset");

    for (genvar s = 0; s < NUM_STRANDS; s++) begin : g_chk
        a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            spec_fail_o[s] |=> !spec_fail_o[s])
            else $error("R7: fail pulse longer than one cycle");

        a_r8_end_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            end_mask_i[s] |=> !spec_fail_o[s])
            else $error("R8: fail raised alongside end command");

        a_r2_fail_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
            spec_fail_o[s] |-> $past(inv_valid_i || evict_valid_i))
            else $error("R2: fail without invalidate or evict");
    end

endmodule

bind spec_read_tracker spec_read_tracker_chk #(
    .NUM_STRANDS (NUM_STRANDS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .inv_valid_i   (inv_valid_i),
    .evict_valid_i (evict_valid_i),
    .end_mask_i    (end_mask_i),
    .spec_fail_o   (spec_fail_o)
);

// File: tb/sim_spec_read_tracker.sv
`timescale 1ns/1ps
module sim_spec_read_tracker;

    localparam int LINES = 64;
    localparam int NS    = 2;

    typedef struct packed {
        logic       lv;
        logic [5:0] ll;
        logic       ls;
        logic       iv;
        logic [5:0] il;
        logic       ev;
        logic [5:0] el;
        logic [1:0] em;
        logic [1:0] ex;
        logic [3:0] rq;
    } vec_t;

    function automatic vec_t v(int lv, int ll, int ls, int iv, int il,
                               int ev, int el, int em, int ex, int rq);
        vec_t r;
        r.lv = 1'(lv); r.ll = 6'(ll); r.ls = 1'(ls);
        r.iv = 1'(iv); r.il = 6'(il); r.ev = 1'(ev); r.el = 6'(el);
        r.em = 2'(em); r.ex = 2'(ex); r.rq = 4'(rq);
        return r;
    endfunction

    localparam int N = 44;
    // fields: load v/line/strand, inv v/line, evict v/line, end mask, expected fail, req
    localparam vec_t TBL [N] = '{
        v(1, 5,0, 0, 0, 0, 0, 0,0, 2),  // R2 mark line 5 for s0
        v(0, 0,0, 1, 5, 0, 0, 0,1, 2),  // R2 invalidate -> s0 fails
        v(0, 0,0, 0, 0, 0, 0, 0,0, 2),  // R2 pulse lasts one cycle
        v(0, 0,0, 1, 5, 0, 0, 0,0, 7),  // R7 no second pulse while FAILED
        v(1, 9,0, 0, 0, 0, 0, 0,0, 7),  // R7 load ignored while FAILED
        v(0, 0,0, 0, 0, 0, 0, 1,0, 5),  // R5 end s0
        v(0, 0,0, 1, 9, 0, 0, 0,0, 7),  // R7 line 9 never marked
        v(1, 3,1, 0, 0, 0, 0, 0,0, 3),  // R3 s1 marks 3
        v(1, 7,0, 0, 0, 0, 0, 0,0, 3),  // s0 marks 7
        v(0, 0,0, 0, 0, 1, 3, 0,2, 3),  // R3 evict 3 -> only s1
        v(0, 0,0, 1, 7, 0, 0, 0,1, 4),  // R4 s0 unaffected before, fails now
        v(0, 0,0, 0, 0, 0, 0, 3,0, 5),  // R5 end both
        v(1,20,0, 1,20, 0, 0, 0,1, 6),  // R6 load+inv same line
        v(0, 0,0, 0, 0, 0, 0, 1,0, 5),
        v(1,40,1, 0, 0, 1,40, 0,2, 6),  // R6 load+evict same line
        v(0, 0,0, 0, 0, 0, 0, 2,0, 5),
        v(1,11,0, 0, 0, 0, 0, 0,0, 4),  // s0 marks 11
        v(0, 0,0, 1,12, 0, 0, 0,0, 4),  // R4 unmarked line 12
        v(1,11,1, 0, 0, 0, 0, 0,0, 4),  // s1 marks 11
        v(0, 0,0, 0, 0, 0, 0, 1,0, 5),  // R5 clear s0 only
        v(0, 0,0, 1,11, 0, 0, 0,2, 5),  // R5 s1 kept, s0 cleared
        v(0, 0,0, 0, 0, 0, 0, 2,0, 5),
        v(1,60,0, 0, 0, 0, 0, 0,0, 9),
        v(1,61,0, 0, 0, 0, 0, 0,0, 9),
        v(0, 0,0, 1,60, 1,61, 0,1, 9),  // R9 hit by both -> one pulse
        v(0, 0,0, 0, 0, 0, 0, 1,0, 9),  // R9 pulse not repeated
        v(1,30,0, 0, 0, 0, 0, 0,0, 8),
        v(0, 0,0, 1,30, 0, 0, 1,0, 8),  // R8 end beats conflict
        v(0, 0,0, 1,30, 0, 0, 0,0, 8),  // R8 marks gone
        v(1,50,1, 0, 0, 0, 0, 2,0, 8),  // R8 end drops load
        v(0, 0,0, 0, 0, 1,50, 0,0, 8),  // R8 line 50 not marked
        v(1,63,1, 0, 0, 0, 0, 0,0, 3),  // R3 top line
        v(1, 0,0, 0, 0, 0, 0, 0,0, 2),  // R2 line 0
        v(0, 0,0, 0, 0, 1,63, 0,2, 3),
        v(0, 0,0, 1, 0, 0, 0, 0,1, 2),
        v(0, 0,0, 0, 0, 0, 0, 3,0, 5),
        v(1,15,0, 0, 0, 0, 0, 0,0, 4),
        v(1,15,1, 0, 0, 0, 0, 0,0, 4),
        v(0, 0,0, 1,15, 0, 0, 0,3, 4),  // R4 every marking strand fails
        v(0, 0,0, 0, 0, 0, 0, 3,0, 5),
        v(1,33,0, 0, 0, 0, 0, 0,0, 9),
        v(1,34,1, 0, 0, 0, 0, 0,0, 9),
        v(0, 0,0, 1,33, 1,34, 0,3, 9),  // R9 both events checked
        v(0, 0,0, 0, 0, 0, 0, 3,0, 9)
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_valid_i = 1'b0;
    logic [5:0]    ld_line_i = '0;
    logic          ld_strand_i = 1'b0;
    logic          inv_valid_i = 1'b0;
    logic [5:0]    inv_line_i = '0;
    logic          evict_valid_i = 1'b0;
    logic [5:0]    evict_line_i = '0;
    logic [NS-1:0] end_mask_i = '0;
    logic [NS-1:0] spec_fail_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    spec_read_tracker #(.NUM_LINES(LINES), .NUM_STRANDS(NS)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .ld_valid_i    (ld_valid_i),
        .ld_line_i     (ld_line_i),
        .ld_strand_i   (ld_strand_i),
        .inv_valid_i   (inv_valid_i),
        .inv_line_i    (inv_line_i),
        .evict_valid_i (evict_valid_i),
        .evict_line_i  (evict_line_i),
        .end_mask_i    (end_mask_i),
        .spec_fail_o   (spec_fail_o)
    );

    task automatic check(input logic [NS-1:0] exp, input int rq, input int row);
        checks++;
        if (spec_fail_o !== exp) begin
            errors++;
            $display("FAIL R%0d row %0d: spec_fail_o=%b expected %b",
                     rq, row, spec_fail_o, exp);
        end
    endtask

    // Called at a falling edge: drive, pass a rising edge, stop at next falling edge
    task automatic apply(input vec_t t);
        ld_valid_i    = t.lv;
        ld_line_i     = t.ll;
        ld_strand_i   = t.ls;
        inv_valid_i   = t.iv;
        inv_line_i    = t.il;
        evict_valid_i = t.ev;
        evict_line_i  = t.el;
        end_mask_i    = t.em;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check('0, 1, -1);                  // R1 output low in reset
        rst_n = 1'b1;
        @(negedge clk);
        check('0, 1, -1);                  // R1 output low after release

        for (int i = 0; i < N; i++) begin
            apply(TBL[i]);
            check(TBL[i].ex, int'(TBL[i].rq), i);
        end

        // R1: reset discards marks taken before it
        apply(v(1, 1,0, 0,0, 0,0, 0,0, 1));
        check('0, 1, 100);
        apply(v(1, 2,1, 0,0, 0,0, 0,0, 1));
        check('0, 1, 101);
        rst_n = 1'b0;
        apply(v(0, 0,0, 0,0, 0,0, 0,0, 1));
        check('0, 1, 102);
        rst_n = 1'b1;
        apply(v(0, 0,0, 1,1, 1,2, 0,0, 1));
        check('0, 1, 103);                 // R1 no fail after reset

        // R2: tracking works again after reset
        apply(v(1, 4,1, 0,0, 0,0, 0,0, 2));
        apply(v(0, 0,0, 1,4, 0,0, 0,2, 2));
        check(2'b10, 2, 104);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule